// File: doc/BRIEF.md
# Clock divider tree controller

The block turns one source clock into a set of derived clock enables. A power-of-two predivider sets the rate of the high-frequency enable. A power-of-two prescaler divides that enable again to give the system enable. Four independent 16-bit integer dividers also divide the high-frequency enable, one for each peripheral enable. Every derived clock is a one-cycle enable pulse in the source domain, so downstream logic keeps a single clock net and gates its registers with the pulse.

Software sets the block up through a plain write port. Address 0 holds the select word with both power-of-two codes. Addresses 1 to 4 hold the control words of peripheral dividers 0 to 3. A divider applies a changed setting only at its terminal count, so a setting change never cuts a period short.

Top module: `clk_div_tree`

## Requirements
- R1: A write with wr_en_i high is captured on the next rising clock edge. At address 0, bits 1:0 are the predivider code and bits 3:2 are the prescaler code. At addresses 1 to 4, peripheral divider 0 to 3 takes bit 0 as its enable and bits 23:8 as its divide value N. Writes to addresses 5 to 7 have no effect.
- R2: Predivider code c (0 to 3) makes hf_en_o pulse once every 2^c source cycles. With code 0, hf_en_o stays high.
- R3: After reset the predivider divides by 4 (code 2), the prescaler divides by 1 (code 0), and all peripheral dividers are disabled with peri_en_o low.
- R4: Prescaler code s makes sys_en_o pulse once every 2^s hf_en_o pulses, and sys_en_o is high only in cycles where hf_en_o is high.
- R5: An enabled peripheral divider with value N pulses once every N+1 hf_en_o pulses, only in cycles where hf_en_o is high. Its count does not depend on the prescaler, and N=0 makes it follow hf_en_o.
- R6: A disabled peripheral divider keeps its output low and clears its count. After it is enabled, its first pulse comes on the (N+1)th hf_en_o pulse. An N written while the divider is disabled is used from the first period.
- R7: A changed code or divide value takes effect only when the running period reaches its terminal count, so the period in progress keeps its old length.
- R8: Two hf_en_o pulses are never more than 8 source cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Source clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address (0 select word, 1..4 peripheral control) |
| wr_data_i | input | 32 | Register write data |
| hf_en_o | output | 1 | High-frequency clock enable pulse |
| sys_en_o | output | 1 | System clock enable pulse |
| peri_en_o | output | 4 | Peripheral clock enable pulses, one per divider |

## Verification
The assertions take three things for granted: the source clock runs freely, reset is released once, and every write presents a legal 2-bit code in the select word. Under those conditions sys_en_o and peri_en_o can only pulse together with hf_en_o, and the high-frequency gap stays within eight cycles whatever order the writes come in. The stimulus drives all inputs on the falling edge and holds each write for exactly one cycle. It changes settings both at rest and part way through a period, and random draws keep divide values small. The one 65536-ratio case is reached by a single directed enable that counts from zero.

// File: rtl/clk_div_tree_pkg.sv
package clk_div_tree_pkg;
  localparam int unsigned CODE_W   = 2;
  localparam int unsigned DIV_W    = 16;
  localparam int unsigned N_PERI   = 4;
  localparam int unsigned ADDR_W   = 3;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned PRE_LSB  = 0;
  localparam int unsigned SYS_LSB  = 2;
  localparam int unsigned EN_BIT   = 0;
  localparam int unsigned DIV_LSB  = 8;
  localparam logic [CODE_W-1:0] PRE_RST = 2'd2;
  localparam logic [CODE_W-1:0] SYS_RST = 2'd0;
  // counter width that holds the largest power-of-two limit
  localparam int unsigned P2_CNT_W = (1 << CODE_W) - 1;
endpackage

// File: rtl/clk_div_pow2.sv
module clk_div_pow2
  import clk_div_tree_pkg::*;
#(
  parameter logic [CODE_W-1:0] RST_CODE = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              tick_o
);
  logic [CODE_W-1:0]   act_q;
  logic [P2_CNT_W-1:0] cnt_q, lim;
  logic                term;

  assign lim    = P2_CNT_W'((1 << act_q) - 1);
  assign term   = (cnt_q == lim);
  assign tick_o = tick_i & term;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= RST_CODE;
      cnt_q <= '0;
    end else if (tick_i) begin
      if (term) begin
        cnt_q <= '0;
        act_q <= code_i;  // new ratio only at terminal count
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/clk_div_int.sv
module clk_div_int
  import clk_div_tree_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             en_i,
  input  logic [DIV_W-1:0] n_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] act_q, cnt_q;
  logic             term;

  assign term   = (cnt_q == act_q);
  assign tick_o = en_i & tick_i & term;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= '0;
      cnt_q <= '0;
    end else if (!en_i) begin
      cnt_q <= '0;
      act_q <= n_i;
    end else if (tick_i) begin
      if (term) begin
        cnt_q <= '0;
        act_q <= n_i;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/clk_div_tree.sv
module clk_div_tree
  import clk_div_tree_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              hf_en_o,
  output logic              sys_en_o,
  output logic [N_PERI-1:0] peri_en_o
);
  logic [CODE_W-1:0] pre_code_q, sys_code_q;
  logic [N_PERI-1:0] peri_on;
  logic [DIV_W-1:0]  peri_n [N_PERI];
  logic              unused_wr;

  assign unused_wr = ^wr_data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_code_q <= PRE_RST;
      sys_code_q <= SYS_RST;
    end else if (wr_en_i && wr_addr_i == '0) begin
      pre_code_q <= wr_data_i[PRE_LSB +: CODE_W];
      sys_code_q <= wr_data_i[SYS_LSB +: CODE_W];
    end
  end

  clk_div_pow2 #(.RST_CODE(PRE_RST)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (1'b1),
    .code_i (pre_code_q),
    .tick_o (hf_en_o)
  );

  clk_div_pow2 #(.RST_CODE(SYS_RST)) u_sys (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (hf_en_o),
    .code_i (sys_code_q),
    .tick_o (sys_en_o)
  );

  for (genvar i = 0; i < N_PERI; i++) begin : g_peri
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(i + 1);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        peri_on[i] <= 1'b0;
        peri_n[i]  <= '0;
      end else if (wr_en_i && wr_addr_i == MY_ADDR) begin
        peri_on[i] <= wr_data_i[EN_BIT];
        peri_n[i]  <= wr_data_i[DIV_LSB +: DIV_W];
      end
    end

    clk_div_int u_div (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .tick_i (hf_en_o),
      .en_i   (peri_on[i]),
      .n_i    (peri_n[i]),
      .tick_o (peri_en_o[i])
    );
  end
endmodule

// File: rtl/clk_div_tree_chk.sv
module clk_div_tree_chk
  import clk_div_tree_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              hf_en_o,
  input logic              sys_en_o,
  input logic [N_PERI-1:0] peri_en_o,
  input logic [N_PERI-1:0] peri_on
);
  logic [3:0] gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                gap_q <= '0;
    else if (hf_en_o)           gap_q <= '0;
    else if (gap_q != 4'hf)     gap_q <= gap_q + 1'b1;
  end

  p_sys_in_hf_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_en_o |-> hf_en_o);

  p_hf_gap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gap_q < 4'd8);

  for (genvar i = 0; i < N_PERI; i++) begin : g_a
    p_peri_in_hf_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      peri_en_o[i] |-> hf_en_o);
    p_off_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(peri_on[i]) |-> !peri_en_o[i]);
  end
endmodule

bind clk_div_tree clk_div_tree_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .hf_en_o   (hf_en_o),
  .sys_en_o  (sys_en_o),
  .peri_en_o (peri_en_o),
  .peri_on   (peri_on)
);

// File: tb/clk_div_tree_test.sv
`timescale 1ns/1ps
module clk_div_tree_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  wr_addr_i = '0;
  logic [31:0] wr_data_i = '0;
  logic        hf_en_o, sys_en_o;
  logic [3:0]  peri_en_o;

  int errs = 0;
  int checks = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  clk_div_tree uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .hf_en_o(hf_en_o), .sys_en_o(sys_en_o), .peri_en_o(peri_en_o)
  );

  function automatic logic pick(int s);
    if (s == 0) return hf_en_o;
    if (s == 1) return sys_en_o;
    return peri_en_o[s-2];
  endfunction

  function automatic logic [31:0] sel_word(int pre, int sys);
    return 32'((sys << 2) | pre);
  endfunction

  function automatic logic [31:0] ctl_word(bit en, int n);
    return (32'(n) << 8) | 32'(en);
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(int addr, logic [31:0] data);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = 3'(addr); wr_data_i = data;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic wait_pulse(int s);
    int n = 0;
    do begin
      @(negedge clk_i);
      n++;
    end while (!pick(s) && n < 70000);
  endtask

  task automatic gap(int s, output int g);
    g = 0;
    do begin
      @(negedge clk_i);
      g++;
    end while (!pick(s) && g < 70000);
  endtask

  task automatic meas(string req, int s, int exp);
    int g;
    wait_pulse(s);
    wait_pulse(s);
    gap(s, g);
    check(req, g, exp);
  endtask

  task automatic quiet(string req, int s, int cyc);
    int seen = 0;
    for (int k = 0; k < cyc; k++) begin
      @(negedge clk_i);
      if (pick(s)) seen++;
    end
    check(req, seen, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    errs++; checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int g, n;
    int rn [4];
    int rp;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk_i);
    // R3: outputs quiet in reset
    check("R3 reset peri", int'(peri_en_o), 0);
    rst_ni = 1'b1;
    for (int i = 0; i < 4; i++) quiet("R3 peri disabled", 2 + i, 20);
    meas("R3 hf default /4", 0, 4);
    meas("R3 sys default /1", 1, 4);

    // R2: predivider codes
    for (int c = 0; c < 4; c++) begin
      wr(0, sel_word(c, 0));
      meas("R2 hf code", 0, 1 << c);
    end
    // R4: prescaler codes on undivided source, then stacked
    for (int c = 0; c < 4; c++) begin
      wr(0, sel_word(0, c));
      meas("R4 sys code", 1, 1 << c);
    end
    wr(0, sel_word(1, 2));
    meas("R4 sys stacked", 1, 8);
    // R1: ignored address
    wr(5, 32'hffff_ffff);
    meas("R1 addr5 no effect sys", 1, 8);
    quiet("R1 addr5 no effect peri", 2, 40);

    // R5: peripheral fed by hf, not sys
    wr(0, sel_word(0, 3));
    wr(1, ctl_word(1, 0));
    meas("R5 N0 follows hf", 2, 1);
    wr(1, ctl_word(1, 1));
    meas("R5 N1", 2, 2);
    wr(0, sel_word(2, 1));
    meas("R5 N1 pre4", 2, 8);

    // R6: divide 65536, N loaded while disabled
    wr(0, sel_word(0, 0));
    wr(1, ctl_word(0, 65535));
    wr(1, ctl_word(1, 65535));
    n = 1;
    while (!peri_en_o[0] && n < 70000) begin
      @(negedge clk_i);
      n++;
    end
    check("R6 first pulse N65535", n, 65536);
    // R6: disable mid-count clears counter
    wr(1, ctl_word(1, 5));
    wait_pulse(2);
    wait_pulse(2);
    repeat (2) @(negedge clk_i);
    wr(1, ctl_word(0, 5));
    quiet("R6 disabled quiet", 2, 30);
    wr(1, ctl_word(1, 5));
    n = 1;
    while (!peri_en_o[0] && n < 1000) begin
      @(negedge clk_i);
      n++;
    end
    check("R6 restart full period", n, 6);

    // R7: change mid-period completes the old period
    wr(2, ctl_word(1, 9));
    wait_pulse(3);
    wait_pulse(3);
    n = 0;
    do begin
      @(negedge clk_i);
      n++;
      if (n == 3) begin
        wr_en_i = 1'b1; wr_addr_i = 3'd2; wr_data_i = ctl_word(1, 2);
      end else wr_en_i = 1'b0;
    end while (!peri_en_o[1] && n < 1000);
    wr_en_i = 1'b0;
    check("R7 old period kept", n, 10);
    gap(3, g);
    check("R7 new period", g, 3);
    // R7: predivider change mid-period
    wr(0, sel_word(3, 0));
    wait_pulse(0);
    repeat (2) @(negedge clk_i);
    wr(0, sel_word(0, 0));
    n = 4;
    while (!hf_en_o && n < 100) begin
      @(negedge clk_i);
      n++;
    end
    check("R7 hf old period kept", n, 8);

    // R5: random mixes on all four dividers
    for (int t = 0; t < 6; t++) begin
      rp = int'($urandom % 3);
      wr(0, sel_word(rp, int'($urandom % 4)));
      for (int i = 0; i < 4; i++) begin
        rn[i] = int'($urandom % 12);
        wr(1 + i, ctl_word(1, rn[i]));
      end
      for (int i = 0; i < 4; i++)
        meas("R5 random period", 2 + i, (rn[i] + 1) << rp);
    end
    finish_run();
  end
endmodule